// File: doc/BRIEF.md
# Selectable Reference Divider and Phase Detector

This block is the digital core of a frequency synthesizer loop. It divides the reference clock by one of two powers of two to make the comparison frequency. It compares that frequency against a feedback pulse stream, which comes from the loop's programmable divider, in a three-state phase/frequency detector. The detector output is a pair of charge-pump enables, one to source and one to sink. A two-bit control field can override the detector to hold one source on permanently, or to put both sources off, which is the high-impedance state. One more control bit raises a flag that selects the larger pump current.

Three band-switch enables are registered out to the band outputs. In test mode, the middle output carries the divided reference level and the top output carries the feedback stream divided by two. Each of them is gated by its own enable bit. The analog pump, the amplifier and the crystal oscillator stay outside this block. The block treats `clk` as the reference clock, and `fb_pulse` is a single-cycle pulse in that domain.

Top module: `refdiv_pfd`

## Requirements
- R1: While `rst` is high, and on the first sample after it, every output is 0.
- R2: The reference period is 2**SHORT_LOG2 cycles when `div_sel_a` equals `div_sel_b`, and 2**LONG_LOG2 cycles when they differ (512 and 1024 by default). The divided reference level is high for the first half of each period.
- R3: A change of `div_sel_a`/`div_sel_b` leaves the period in progress unchanged. It takes effect from the next terminal count onward.
- R4: In normal mode, `pump_up` rises on the same clock edge as the divided reference level's rising copy on `band_mid`. A sampled `fb_pulse` sets `pump_dn` on that clock edge. Each enable holds until the pair is cleared.
- R5: In normal mode, when both enables are high they stay high together for exactly RST_DLY cycles (default 1), then both drop to 0.
- R6: The detector mode is {`pd_sel_a`,`pd_sel_b`}. The codes are: 2'b10 normal, 2'b11 both off, 2'b00 `pump_up`=1 and `pump_dn`=0, and 2'b01 `pump_up`=0 and `pump_dn`=1. A forced mode applies one clock after it is presented, whatever the reference and feedback do.
- R7: `pump_hi` equals `pump_hi_en` one clock later.
- R8: With `test_en`=0, `band_lo`, `band_mid` and `band_hi` equal `band_lo_en`, `band_mid_en` and `band_hi_en` one clock later.
- R9: With `test_en`=1, `band_lo` still follows `band_lo_en`. `band_mid` is the reference level ANDed with `band_mid_en`. `band_hi` is a feedback toggle ANDed with `band_hi_en`. The toggle starts at 0 after reset and flips on every sampled `fb_pulse`, and `band_hi` reflects the flip two clocks after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_pulse | input | 1 | One-cycle pulse from the loop's feedback divider |
| div_sel_a | input | 1 | Ratio select bit A |
| div_sel_b | input | 1 | Ratio select bit B |
| pd_sel_a | input | 1 | Detector mode bit A (high bit of the mode code) |
| pd_sel_b | input | 1 | Detector mode bit B (low bit of the mode code) |
| test_en | input | 1 | Routes the internal clocks onto the band outputs |
| pump_hi_en | input | 1 | High pump-current request |
| band_lo_en | input | 1 | Low band enable |
| band_mid_en | input | 1 | Middle band enable, also the gate for the reference in test mode |
| band_hi_en | input | 1 | High band enable, also the gate for the feedback toggle in test mode |
| pump_up | output | 1 | Source enable for the charge pump |
| pump_dn | output | 1 | Sink enable for the charge pump |
| pump_hi | output | 1 | High-current select flag |
| band_lo | output | 1 | Low band output |
| band_mid | output | 1 | Middle band output |
| band_hi | output | 1 | High band output |

## Verification
The latency of each result, counted from the edge that samples the stimulus, is as follows:
- Band outputs, the pump-current flag and forced detector modes settle after one edge.
- A feedback pulse sets `pump_dn` on its sampling edge.
- The feedback toggle reaches `band_hi` one edge after that.
- `pump_up` rises on the same edge as `band_mid` in test mode.

The bench therefore drives and samples on falling edges. It uses the rising edge of `band_mid` as its time base for the detector, and counts the periods between successive rises to check the ratio and when a ratio change takes effect. The reference divider is shrunk to 8/16 cycles so that every ratio code and detector mode can be swept.

// File: rtl/refdiv_pfd_pkg.sv
package refdiv_pfd_pkg;

  // Detector mode, code = {pd_sel_a, pd_sel_b}
  typedef enum logic [1:0] {
    PD_UP_ONLY = 2'b00,
    PD_DN_ONLY = 2'b01,
    PD_NORMAL  = 2'b10,
    PD_OFF     = 2'b11
  } pd_mode_e;

  // Unequal select bits choose the long ratio
  function automatic logic pick_long(input logic a, input logic b);
    return a ^ b;
  endfunction

endpackage

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int SHORT_LOG2 = 9,
  parameter int LONG_LOG2  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_long,
  output logic ref_tick,
  output logic ref_lvl
);
  localparam int CNT_W = LONG_LOG2;
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'((2 ** SHORT_LOG2) - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'((2 ** LONG_LOG2) - 1);
  localparam logic [CNT_W-1:0] SHORT_HALF = CNT_W'(2 ** (SHORT_LOG2 - 1));
  localparam logic [CNT_W-1:0] LONG_HALF  = CNT_W'(2 ** (LONG_LOG2 - 1));

  logic [CNT_W-1:0] cnt_q, cnt_nx, half_nx;
  logic             long_q, long_nx, wrap;

  always_comb begin
    wrap    = (cnt_q == (long_q ? LONG_LAST : SHORT_LAST));
    cnt_nx  = wrap ? '0 : cnt_q + CNT_W'(1);
    long_nx = wrap ? sel_long : long_q;
    half_nx = long_nx ? LONG_HALF : SHORT_HALF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      long_q   <= 1'b0;
      ref_tick <= 1'b0;
      ref_lvl  <= 1'b0;
    end else begin
      cnt_q    <= cnt_nx;
      long_q   <= long_nx;
      ref_tick <= wrap;
      ref_lvl  <= (cnt_nx < half_nx);
    end
  end

  // R3
  ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(long_q));

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    ref_tick |=> !ref_tick);

endmodule

// File: rtl/refdiv_detector.sv
module refdiv_detector
  import refdiv_pfd_pkg::*;
#(
  parameter int RST_DLY = 1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     ref_tick,
  input  logic     fb_tick,
  input  pd_mode_e mode,
  output logic     up_q,
  output logic     dn_q
);
  localparam int DLY_W = $clog2(RST_DLY + 1);
  localparam int RUN_W = DLY_W + 1;

  logic [DLY_W-1:0] dly_q;
  logic             both, clr;

  always_comb begin
    both = up_q & dn_q;
    clr  = both && (dly_q == DLY_W'(RST_DLY - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      dly_q <= '0;
    end else begin
      unique case (mode)
        PD_NORMAL: begin
          up_q  <= ref_tick | (up_q & ~clr);
          dn_q  <= fb_tick  | (dn_q & ~clr);
          dly_q <= (both && !clr) ? dly_q + DLY_W'(1) : '0;
        end
        PD_UP_ONLY: begin
          up_q  <= 1'b1;
          dn_q  <= 1'b0;
          dly_q <= '0;
        end
        PD_DN_ONLY: begin
          up_q  <= 1'b0;
          dn_q  <= 1'b1;
          dly_q <= '0;
        end
        default: begin
          up_q  <= 1'b0;
          dn_q  <= 1'b0;
          dly_q <= '0;
        end
      endcase
    end
  end

  // checker: length of the current overlap run
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)                      run_q <= '0;
    else if (!both)               run_q <= '0;
    else if (run_q != {RUN_W{1'b1}}) run_q <= run_q + RUN_W'(1);
  end

  // R5
  overlap_len_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == PD_NORMAL && both) |-> (run_q < RUN_W'(RST_DLY)));

  // R4
  ref_sets_up_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == PD_NORMAL && ref_tick) |=> up_q);

  // R4
  fb_sets_dn_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == PD_NORMAL && fb_tick) |=> dn_q);

  // R6
  forced_no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != PD_NORMAL) |=> !(up_q && dn_q));

  // R6
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == PD_OFF) |=> (!up_q && !dn_q));

endmodule

// File: rtl/refdiv_outstage.sv
module refdiv_outstage (
  input  logic clk,
  input  logic rst,
  input  logic test_en,
  input  logic pump_hi_en,
  input  logic lo_en,
  input  logic mid_en,
  input  logic hi_en,
  input  logic ref_lvl,
  input  logic fb_tick,
  output logic band_lo,
  output logic band_mid,
  output logic band_hi,
  output logic pump_hi
);
  logic fb_half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_half_q <= 1'b0;
      band_lo   <= 1'b0;
      band_mid  <= 1'b0;
      band_hi   <= 1'b0;
      pump_hi   <= 1'b0;
    end else begin
      if (fb_tick) fb_half_q <= ~fb_half_q;
      band_lo  <= lo_en;
      band_mid <= mid_en & (test_en ? ref_lvl : 1'b1);
      band_hi  <= hi_en  & (test_en ? fb_half_q : 1'b1);
      pump_hi  <= pump_hi_en;
    end
  end

  // R7
  pump_hi_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pump_hi == $past(pump_hi_en)));

  // R8
  band_plain_chk: assert property (@(posedge clk) disable iff (rst)
    !test_en |=> (band_mid == $past(mid_en) && band_hi == $past(hi_en)));

  // R9
  band_lo_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (band_lo == $past(lo_en)));

  // R9
  test_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (test_en && !mid_en) |=> !band_mid);

endmodule

// File: rtl/refdiv_pfd.sv
module refdiv_pfd
  import refdiv_pfd_pkg::*;
#(
  parameter int SHORT_LOG2 = 9,
  parameter int LONG_LOG2  = 10,
  parameter int RST_DLY    = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic fb_pulse,
  input  logic div_sel_a,
  input  logic div_sel_b,
  input  logic pd_sel_a,
  input  logic pd_sel_b,
  input  logic test_en,
  input  logic pump_hi_en,
  input  logic band_lo_en,
  input  logic band_mid_en,
  input  logic band_hi_en,
  output logic pump_up,
  output logic pump_dn,
  output logic pump_hi,
  output logic band_lo,
  output logic band_mid,
  output logic band_hi
);
  logic     ref_tick, ref_lvl, sel_long;
  pd_mode_e mode;

  always_comb begin
    sel_long = pick_long(div_sel_a, div_sel_b);
    mode     = pd_mode_e'({pd_sel_a, pd_sel_b});
  end

  refdiv_counter #(
    .SHORT_LOG2(SHORT_LOG2),
    .LONG_LOG2 (LONG_LOG2)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .sel_long(sel_long),
    .ref_tick(ref_tick),
    .ref_lvl (ref_lvl)
  );

  refdiv_detector #(
    .RST_DLY(RST_DLY)
  ) u_det (
    .clk     (clk),
    .rst     (rst),
    .ref_tick(ref_tick),
    .fb_tick (fb_pulse),
    .mode    (mode),
    .up_q    (pump_up),
    .dn_q    (pump_dn)
  );

  refdiv_outstage u_out (
    .clk       (clk),
    .rst       (rst),
    .test_en   (test_en),
    .pump_hi_en(pump_hi_en),
    .lo_en     (band_lo_en),
    .mid_en    (band_mid_en),
    .hi_en     (band_hi_en),
    .ref_lvl   (ref_lvl),
    .fb_tick   (fb_pulse),
    .band_lo   (band_lo),
    .band_mid  (band_mid),
    .band_hi   (band_hi),
    .pump_hi   (pump_hi)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !(pump_up || pump_dn || pump_hi || band_lo || band_mid || band_hi));

endmodule

// File: tb/refdiv_pfd_tb.sv
module refdiv_pfd_tb;
  localparam int SL = 3;
  localparam int LL = 4;
  localparam int NS = 2 ** SL;
  localparam int NL = 2 ** LL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fb_pulse = 0, div_sel_a = 0, div_sel_b = 0, pd_sel_a = 1, pd_sel_b = 0;
  logic test_en = 0, pump_hi_en = 0, band_lo_en = 0, band_mid_en = 0, band_hi_en = 0;
  logic pump_up, pump_dn, pump_hi, band_lo, band_mid, band_hi;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit hi_par = 0;

  always #5 clk = ~clk;

  refdiv_pfd #(.SHORT_LOG2(SL), .LONG_LOG2(LL), .RST_DLY(1)) u_dut (
    .clk(clk), .rst(rst), .fb_pulse(fb_pulse),
    .div_sel_a(div_sel_a), .div_sel_b(div_sel_b),
    .pd_sel_a(pd_sel_a), .pd_sel_b(pd_sel_b),
    .test_en(test_en), .pump_hi_en(pump_hi_en),
    .band_lo_en(band_lo_en), .band_mid_en(band_mid_en), .band_hi_en(band_hi_en),
    .pump_up(pump_up), .pump_dn(pump_dn), .pump_hi(pump_hi),
    .band_lo(band_lo), .band_mid(band_mid), .band_hi(band_hi)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // single-cycle feedback pulse, ends on the next sample
  task automatic pulse_fb();
    fb_pulse = 1'b1;
    hi_par   = ~hi_par;
    step();
    fb_pulse = 1'b0;
  endtask

  // returns at the sample where band_mid has just gone high
  task automatic wait_rise(output int gap);
    logic prev;
    prev = band_mid;
    gap  = 0;
    for (int i = 0; i < 64; i++) begin
      step();
      gap++;
      if (band_mid && !prev) return;
      prev = band_mid;
    end
    gap = -1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(1_500_000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int g, hl;
    repeat (3) step();
    chk("R1 reset outputs", {pump_up, pump_dn, pump_hi, band_lo, band_mid, band_hi}, 0);
    rst = 1'b0;
    step();
    chk("R1 first sample after reset", {pump_up, pump_dn, pump_hi, band_lo, band_mid, band_hi}, 0);

    // R8: all enable patterns with test off
    for (int v = 0; v < 8; v++) begin
      {band_hi_en, band_mid_en, band_lo_en} = 3'(v);
      step();
      chk("R8 plain band copy", {band_hi, band_mid, band_lo}, v);
    end

    // R7
    pump_hi_en = 1; step(); chk("R7 pump_hi set", pump_hi, 1);
    pump_hi_en = 0; step(); chk("R7 pump_hi clear", pump_hi, 0);

    // test mode
    test_en = 1; band_lo_en = 1; band_mid_en = 1; band_hi_en = 1;
    step();
    chk("R9 band_lo unaffected", band_lo, 1);
    chk("R9 band_hi toggle starts low", band_hi, 0);

    // R2: every ratio code
    for (int c = 0; c < 4; c++) begin
      {div_sel_a, div_sel_b} = 2'(c);
      wait_rise(g); wait_rise(g);
      hl = 0;
      for (int i = 0; i < 20 && band_mid; i++) begin step(); hl++; end
      chk("R2 reference high time", hl, ((c == 1 || c == 2) ? NL : NS) / 2);
      wait_rise(g); wait_rise(g);
      chk("R2 reference period", g, (c == 1 || c == 2) ? NL : NS);
    end

    // R3: change applies from the next terminal count
    {div_sel_a, div_sel_b} = 2'b11;
    wait_rise(g); wait_rise(g);
    {div_sel_a, div_sel_b} = 2'b01;
    wait_rise(g); chk("R3 old short period kept", g, NS);
    wait_rise(g); chk("R3 new long period", g, NL);
    {div_sel_a, div_sel_b} = 2'b00;
    wait_rise(g); chk("R3 old long period kept", g, NL);
    wait_rise(g); chk("R3 new short period", g, NS);

    // clear detector: off for one cycle, then normal
    {pd_sel_a, pd_sel_b} = 2'b11; step();
    chk("R6 off clears", {pump_up, pump_dn}, 0);
    {pd_sel_a, pd_sel_b} = 2'b10;

    // R4/R5: reference leads
    wait_rise(g);
    chk("R4 up rises with reference", {pump_up, pump_dn}, 2'b10);
    step();
    pulse_fb();
    chk("R4 R5 both set after feedback", {pump_up, pump_dn}, 2'b11);
    step();
    chk("R5 both cleared after one cycle", {pump_up, pump_dn}, 2'b00);
    chk("R9 band_hi follows feedback toggle", band_hi, hi_par);

    // R4/R5: feedback leads
    pulse_fb();
    chk("R4 dn set by feedback", {pump_up, pump_dn}, 2'b01);
    step();
    chk("R4 dn held", {pump_up, pump_dn}, 2'b01);
    chk("R9 band_hi second toggle", band_hi, hi_par);
    wait_rise(g);
    chk("R5 overlap at reference", {pump_up, pump_dn}, 2'b11);
    step();
    chk("R5 overlap ends", {pump_up, pump_dn}, 2'b00);

    // R6: forced modes over more than one reference period with feedback
    for (int m = 0; m < 3; m++) begin
      logic [1:0] code;
      code = (m == 0) ? 2'b00 : (m == 1) ? 2'b01 : 2'b11;
      {pd_sel_a, pd_sel_b} = code;
      step();
      for (int i = 0; i < 12; i++) begin
        if (i % 3 == 1) pulse_fb(); else step();
        chk("R6 forced detector mode", {pump_up, pump_dn},
            (code == 2'b00) ? 2'b10 : (code == 2'b01) ? 2'b01 : 2'b00);
      end
    end
    {pd_sel_a, pd_sel_b} = 2'b10;

    // R9 gating in test mode
    band_mid_en = 0; band_hi_en = 0;
    for (int i = 0; i < NL + 2; i++) begin
      if (i == 4) pulse_fb(); else step();
      if (i > 0) chk("R9 gated outputs low", {band_mid, band_hi}, 0);
    end
    band_hi_en = 1; step();
    chk("R9 band_hi shows toggle parity", band_hi, hi_par);

    finish_run();
  end
endmodule